// File: doc/BRIEF.md
# Serial-Link Watchdog Operating-Mode Controller

This block is the operating-mode sequencer for a two-channel driver that is configured over a serial link. After power-on it holds a short reset phase. It then waits for the host to prove the link works, gives the host a window to preload the fallback settings, and enters normal running. An optional watchdog counter measures the time since the last valid frame from the serial front end. The stage at which that counter expires decides where the device goes next. Silence during start-up leaves the device running on its own from its pin inputs with the serial port switched off. Silence during normal running switches the channels over to the preloaded fallback settings bank.

The front end gives one strobe for each frame it accepts. The register file supplies the watchdog enable, the timeout length, a level-held sleep request and a one-cycle soft-reset pulse. The block's outputs are the current mode, a serial-port enable, a select between the normal and the fallback register banks, and the per-channel enables gated by mode.

Top module: `comm_wdog_mode_ctrl`

## Requirements
- R1: Mode codes are POR=0, DETECT=1, STANDALONE=2, LOAD=3, RUN=4, SLEEP=5, LIMP=6. After reset is released the mode stays POR for POR_CYCLES clock cycles and then becomes DETECT.
- R2: With wdogEn low, DETECT moves to LOAD and LOAD moves to RUN, one clock cycle each, and no timeout transition happens.
- R3: With wdogEn high, DETECT moves to LOAD and LOAD moves to RUN only on a cycle where frameValid is high.
- R4: With wdogEn high, wdogLimit (at least 1) consecutive cycles in DETECT or LOAD without frameValid move the mode to STANDALONE. There spiEn is low, and the mode holds until softReset.
- R5: In RUN with wdogEn high, wdogLimit consecutive cycles without frameValid move the mode to LIMP. Each frame restarts the count.
- R6: LIMP holds until softReset, whatever frames arrive. limpBankSel is high in LIMP and low in every other mode.
- R7: sleepCmd high in RUN moves the mode to SLEEP on the next cycle. SLEEP moves to POR on the first cycle that sleepCmd is low.
- R8: softReset high moves the mode to POR on the next cycle from any mode, ahead of every other condition, and restarts the POR dwell.
- R9: chanOn[i] equals chEnIn[i] in STANDALONE, RUN and LIMP, and is 0 in all other modes.
- R10: In RUN with wdogEn low, frames and elapsed time have no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| frameValid | input | 1 | One-cycle strobe per valid frame from the serial front end |
| wdogEn | input | 1 | Watchdog enable |
| wdogLimit | input | CNT_W | Timeout length in cycles without a frame |
| sleepCmd | input | 1 | Sleep request, level |
| softReset | input | 1 | One-cycle write strobe of the reset register |
| chEnIn | input | NUM_CH | Per-channel external enable inputs |
| mode | output | 3 | Current operating mode |
| spiEn | output | 1 | Serial port enabled (low only in STANDALONE) |
| limpBankSel | output | 1 | Selects the fallback register bank |
| chanOn | output | NUM_CH | Mode-gated channel enables |

## Verification
Each mode change is registered and shows on the mode output one clock after the edge that samples its cause. A timeout takes exactly wdogLimit cycles counted from the entry to the state or from the last frame, and the POR dwell takes exactly POR_CYCLES cycles. spiEn, limpBankSel and chanOn are decoded from the registered mode and the live chEnIn within the same cycle. The bench drives inputs on the falling edge. A cycle model advances on the rising edge, and every output is compared against it on the next falling edge, so each result is sampled in the cycle in which it is due.

// File: rtl/comm_wdog_pkg.sv
package comm_wdog_pkg;
  typedef enum logic [2:0] {
    MODE_POR        = 3'd0,
    MODE_DETECT     = 3'd1,
    MODE_STANDALONE = 3'd2,
    MODE_LOAD       = 3'd3,
    MODE_RUN        = 3'd4,
    MODE_SLEEP      = 3'd5,
    MODE_LIMP       = 3'd6
  } mode_e;

  localparam int MODE_W = 3;

  // control -> timer strobes
  typedef struct packed {
    logic restart;
    logic count;
  } tmr_ctl_t;

  // timer -> control flags
  typedef struct packed {
    logic porDone;
    logic expired;
  } tmr_sts_t;
endpackage

// File: rtl/comm_wdog_timer.sv
module comm_wdog_timer
  import comm_wdog_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int POR_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_ctl_t         ctl,
  input  logic [CNT_W-1:0] wdogLimit,
  output tmr_sts_t         sts
);
  localparam logic [CNT_W-1:0] PorLast = CNT_W'(POR_CYCLES - 1);
  localparam logic [CNT_W-1:0] One     = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (ctl.restart) cnt <= '0;
    else if (ctl.count) cnt <= cnt + One;
  end

  always_comb begin
    sts.porDone = (cnt == PorLast);
    sts.expired = (cnt == (wdogLimit - One));
  end
endmodule

// File: rtl/comm_wdog_fsm.sv
module comm_wdog_fsm
  import comm_wdog_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameValid,
  input  logic     wdogEn,
  input  logic     sleepCmd,
  input  logic     softReset,
  input  tmr_sts_t sts,
  output mode_e    mode,
  output tmr_ctl_t ctl
);
  mode_e nextMode;
  logic  watching;
  logic  timeout;

  always_comb begin
    watching = wdogEn && (mode == MODE_DETECT || mode == MODE_LOAD || mode == MODE_RUN);
    timeout  = watching && sts.expired && !frameValid;
    nextMode = mode;
    if (softReset) begin
      nextMode = MODE_POR;
    end else begin
      case (mode)
        MODE_POR:    if (sts.porDone) nextMode = MODE_DETECT;
        MODE_DETECT: begin
          if (!wdogEn || frameValid) nextMode = MODE_LOAD;
          else if (timeout)          nextMode = MODE_STANDALONE;
        end
        MODE_LOAD: begin
          if (!wdogEn || frameValid) nextMode = MODE_RUN;
          else if (timeout)          nextMode = MODE_STANDALONE;
        end
        MODE_RUN: begin
          if (sleepCmd)     nextMode = MODE_SLEEP;
          else if (timeout) nextMode = MODE_LIMP;
        end
        MODE_SLEEP:      if (!sleepCmd) nextMode = MODE_POR;
        MODE_STANDALONE: nextMode = MODE_STANDALONE;
        MODE_LIMP:       nextMode = MODE_LIMP;
        default:         nextMode = MODE_POR;
      endcase
    end
  end

  always_comb begin
    ctl.count   = (mode == MODE_POR) || watching;
    ctl.restart = softReset || (nextMode != mode) ||
                  (watching && frameValid) || !ctl.count;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_POR;
    else       mode <= nextMode;
  end
endmodule

// File: rtl/comm_wdog_outdec.sv
module comm_wdog_outdec
  import comm_wdog_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  mode_e             mode,
  input  logic [NUM_CH-1:0] chEnIn,
  output logic              spiEn,
  output logic              limpBankSel,
  output logic [NUM_CH-1:0] chanOn
);
  logic chanLive;

  always_comb begin
    spiEn       = (mode != MODE_STANDALONE);
    limpBankSel = (mode == MODE_LIMP);
    chanLive    = (mode == MODE_STANDALONE) || (mode == MODE_RUN) || (mode == MODE_LIMP);
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign chanOn[ch] = chanLive & chEnIn[ch];
  end
endmodule

// File: rtl/comm_wdog_mode_ctrl.sv
module comm_wdog_mode_ctrl
  import comm_wdog_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int POR_CYCLES = 8,
  parameter int NUM_CH     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic              wdogEn,
  input  logic [CNT_W-1:0]  wdogLimit,
  input  logic              sleepCmd,
  input  logic              softReset,
  input  logic [NUM_CH-1:0] chEnIn,
  output logic [MODE_W-1:0] mode,
  output logic              spiEn,
  output logic              limpBankSel,
  output logic [NUM_CH-1:0] chanOn
);
  tmr_ctl_t tmrCtl;
  tmr_sts_t tmrSts;
  mode_e    curMode;

  comm_wdog_timer #(.CNT_W(CNT_W), .POR_CYCLES(POR_CYCLES)) u_timer (
    .clk(clk), .rstN(rstN), .ctl(tmrCtl), .wdogLimit(wdogLimit), .sts(tmrSts)
  );

  comm_wdog_fsm u_fsm (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .wdogEn(wdogEn),
    .sleepCmd(sleepCmd), .softReset(softReset), .sts(tmrSts),
    .mode(curMode), .ctl(tmrCtl)
  );

  comm_wdog_outdec #(.NUM_CH(NUM_CH)) u_outdec (
    .mode(curMode), .chEnIn(chEnIn), .spiEn(spiEn),
    .limpBankSel(limpBankSel), .chanOn(chanOn)
  );

  assign mode = curMode;
endmodule

// File: rtl/comm_wdog_chk.sv
module comm_wdog_chk
  import comm_wdog_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wdogEn,
  input logic              sleepCmd,
  input logic              softReset,
  input logic [MODE_W-1:0] mode,
  input logic              limpBankSel
);
  // R4
  standalone_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_STANDALONE && !softReset) |=> (mode == MODE_STANDALONE));

  // R6
  limp_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_LIMP && !softReset) |=> (mode == MODE_LIMP));

  // R6
  limp_from_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(limpBankSel) |-> ($past(mode) == MODE_RUN));

  // R8
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (mode == MODE_POR));

  // R7
  sleep_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_SLEEP && !sleepCmd && !softReset) |=> (mode == MODE_POR));

  // R10
  no_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RUN && !wdogEn) |=> (mode != MODE_LIMP));
endmodule

bind comm_wdog_mode_ctrl comm_wdog_chk u_chk (
  .clk(clk), .rstN(rstN), .wdogEn(wdogEn), .sleepCmd(sleepCmd),
  .softReset(softReset), .mode(mode), .limpBankSel(limpBankSel)
);

// File: tb/comm_wdog_mode_ctrl_tb.sv
`timescale 1ns/1ps
module comm_wdog_mode_ctrl_tb;
  localparam int CW = 16;
  localparam int PORC = 8;
  localparam int M_POR = 0, M_DET = 1, M_SA = 2, M_LOAD = 3, M_RUN = 4, M_SLP = 5, M_LIMP = 6;

  logic clk = 0;
  logic rstN = 0;
  logic frameValid = 0, wdogEn = 0, sleepCmd = 0, softReset = 0;
  logic [CW-1:0] wdogLimit = 16'd4;
  logic [1:0] chEnIn = 2'b00;
  logic [2:0] mode;
  logic spiEn, limpBankSel;
  logic [1:0] chanOn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  comm_wdog_mode_ctrl u_dut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .wdogEn(wdogEn),
    .wdogLimit(wdogLimit), .sleepCmd(sleepCmd), .softReset(softReset),
    .chEnIn(chEnIn), .mode(mode), .spiEn(spiEn),
    .limpBankSel(limpBankSel), .chanOn(chanOn)
  );

  // cycle reference model built from the requirements
  int mdlMode, mdlCnt, mdlNext;
  bit mdlWatch, mdlCount, mdlRestart;

  always @* begin
    mdlWatch = wdogEn && (mdlMode == M_DET || mdlMode == M_LOAD || mdlMode == M_RUN);
    mdlNext = mdlMode;
    if (softReset) mdlNext = M_POR;
    else if (mdlMode == M_POR) begin
      if (mdlCnt == PORC - 1) mdlNext = M_DET;
    end else if (mdlMode == M_DET || mdlMode == M_LOAD) begin
      if (!wdogEn || frameValid) mdlNext = (mdlMode == M_DET) ? M_LOAD : M_RUN;
      else if (mdlCnt == int'(wdogLimit) - 1) mdlNext = M_SA;
    end else if (mdlMode == M_RUN) begin
      if (sleepCmd) mdlNext = M_SLP;
      else if (wdogEn && !frameValid && mdlCnt == int'(wdogLimit) - 1) mdlNext = M_LIMP;
    end else if (mdlMode == M_SLP) begin
      if (!sleepCmd) mdlNext = M_POR;
    end
    mdlCount = (mdlMode == M_POR) || mdlWatch;
    mdlRestart = softReset || (mdlNext != mdlMode) || (mdlWatch && frameValid) || !mdlCount;
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdlMode <= M_POR;
      mdlCnt <= 0;
    end else begin
      mdlMode <= mdlNext;
      mdlCnt <= mdlRestart ? 0 : mdlCnt + 1;
    end
  end

  function automatic string reqOf(int m);
    case (m)
      M_POR: return "R1";
      M_DET: return "R3";
      M_SA: return "R4";
      M_LOAD: return "R2";
      M_RUN: return "R5";
      M_SLP: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit live;
    live = (mdlMode == M_SA) || (mdlMode == M_RUN) || (mdlMode == M_LIMP);
    checkEq(reqOf(mdlMode), int'(mode), mdlMode);
    checkEq("R4", int'(spiEn), int'(mdlMode != M_SA));
    checkEq("R6", int'(limpBankSel), int'(mdlMode == M_LIMP));
    checkEq("R9", int'(chanOn), live ? int'(chEnIn) : 0);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkEq("R1", int'(mode), M_POR);
    rstN = 1;
    chEnIn = 2'b11;
    // R1 dwell, then R2 with watchdog off
    steps(PORC - 1);
    checkEq("R1", int'(mode), M_POR);
    step(); checkEq("R1", int'(mode), M_DET);
    step(); checkEq("R2", int'(mode), M_LOAD);
    step(); checkEq("R2", int'(mode), M_RUN);
    // R10: no timeout with watchdog off
    frameValid = 1; step(); frameValid = 0;
    steps(20);
    checkEq("R10", int'(mode), M_RUN);
    checkEq("R9", int'(chanOn), 3);
    // R5: run timeout with a restart by a frame
    wdogEn = 1; wdogLimit = 5;
    steps(4);
    checkEq("R5", int'(mode), M_RUN);
    frameValid = 1; step(); frameValid = 0;
    steps(4);
    checkEq("R5", int'(mode), M_RUN);
    step();
    checkEq("R5", int'(mode), M_LIMP);
    checkEq("R6", int'(limpBankSel), 1);
    frameValid = 1; steps(3); frameValid = 0;
    checkEq("R6", int'(mode), M_LIMP);
    // R8 then R4: start-up timeout
    softReset = 1; step(); softReset = 0;
    checkEq("R8", int'(mode), M_POR);
    wdogLimit = 3;
    steps(PORC);
    checkEq("R1", int'(mode), M_DET);
    steps(2);
    checkEq("R4", int'(mode), M_DET);
    step();
    checkEq("R4", int'(mode), M_SA);
    checkEq("R4", int'(spiEn), 0);
    chEnIn = 2'b10; frameValid = 1; steps(3); frameValid = 0;
    checkEq("R4", int'(mode), M_SA);
    checkEq("R9", int'(chanOn), 2);
    // R3 frame-driven start-up, then R7
    softReset = 1; step(); softReset = 0;
    steps(PORC);
    frameValid = 1; step(); frameValid = 0;
    checkEq("R3", int'(mode), M_LOAD);
    checkEq("R9", int'(chanOn), 0);
    steps(2);
    checkEq("R3", int'(mode), M_LOAD);
    frameValid = 1; step(); frameValid = 0;
    checkEq("R3", int'(mode), M_RUN);
    sleepCmd = 1; step();
    checkEq("R7", int'(mode), M_SLP);
    steps(2);
    checkEq("R7", int'(mode), M_SLP);
    sleepCmd = 0; step();
    checkEq("R7", int'(mode), M_POR);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      frameValid = ($urandom % 4) == 0;
      wdogEn = ($urandom % 8) != 0;
      sleepCmd = ($urandom % 40) == 0;
      softReset = ($urandom % 250) == 0;
      chEnIn = 2'($urandom);
      if (softReset) wdogLimit = CW'(1 + $urandom % 8);
      step();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule